// File: doc/BRIEF.md
# Mailbox Command Sequencer (Controller Side)

This block runs the controller's half of a byte-oriented command exchange with a host over a two-port mailbox. The host writes either a command byte or a data byte into the mailbox. The mailbox raises an input-full flag and reports, with the byte, whether it arrived through the command port. The host reads answer bytes from an output-full register. The mailbox register logic sits outside this block. The sequencer sees the mailbox only through one-cycle event pulses, the command-port marker, the received byte and the output-full level. It drives back single-cycle clear and load strobes and two interrupt-enable levels.

Each command byte indexes a parameter table. The table gives the number of bytes the command takes from the host and then the number it returns. A new command always aborts whatever was running. Any byte still waiting in the output register is flushed before the input flag is released, so a polling host can never mistake leftover data for the answer to its new command. Events that arrive while a step is being handled are latched and served one at a time. None is lost, and no step is ever re-entered.

Received bytes leave on a valid/ready stream. While `rx_valid_o` is high and `rx_ready_i` is low, the byte and its marker hold steady and the input flag stays set. Because the input flag stays set, the host is held off. Bytes to return arrive on a second valid/ready stream. `tx_ready_o` is high only while a return byte is due. The load strobe fires in the handshake cycle, so a source that holds `tx_valid_i` low simply stalls the reply.

Top module: `mbx_cmd_sequencer`

## Requirements
- R1: After reset the input interrupt enable is 1, the output interrupt enable is 0, `cmd_busy_o` and `rx_valid_o` are 0, and no clear or load strobe is asserted.
- R2: A byte marked as a command aborts the running command. Its remaining counts are dropped, a latched output event is discarded, and a clear-output strobe is issued only for such a byte.
- R3: When a command byte is taken while the output flag is 1, the clear-output strobe comes in an earlier cycle than the clear-input strobe. The two strobes are never asserted in the same cycle.
- R4: Every command byte, and every data byte expected by the running command, is offered on the receive stream with `rx_is_cmd_o` equal to the command marker. The clear-input strobe is issued only in the cycle the stream handshake completes. A stalled stream holds the byte steady.
- R5: Command byte c < NUM_CMDS uses table entry c at CMD_TABLE[8c+7:8c]. Bits 7:4 give the receive count and bits 3:0 give the send count. All receive bytes are taken before any byte is sent. A command byte of NUM_CMDS or more has both counts 0.
- R6: When the byte being sent is the last one of the command, the output interrupt enable is 0 afterwards and `cmd_busy_o` falls.
- R7: When more bytes follow a sent byte, the output interrupt enable is 1 afterwards. The next byte is loaded only after an output event, that is, after the host has read the current byte.
- R8: While the command waits for host data, or after it has finished, the output interrupt enable is 0. A command whose counts are both 0 leaves `cmd_busy_o` at 0.
- R9: A data byte that arrives when no receive byte is outstanding is cleared from the mailbox. It is not forwarded and has no effect on the sequence.
- R10: Input events are always latched. Output events are latched only while the output interrupt enable is 1. A latched input event is served before a latched output event, and latched events stay pending until served.
- R11: `tx_ready_o` is high only while a return byte is due. The load strobe fires once per handshake and carries `tx_byte_i` on `mb_out_byte_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mb_ibf_evt_i | input | 1 | Pulse: input flag went from 0 to 1 |
| mb_obf_evt_i | input | 1 | Pulse: host read the output byte, so the output flag went from 1 to 0 |
| mb_cmd_i | input | 1 | Held byte came through the command port |
| mb_byte_i | input | CMD_W | Held input byte |
| mb_obf_flag_i | input | 1 | Output flag level |
| mb_clr_ibf_o | output | 1 | Strobe: release the input flag |
| mb_clr_obf_o | output | 1 | Strobe: discard the output byte |
| mb_load_obf_o | output | 1 | Strobe: load `mb_out_byte_o` into the output register |
| mb_out_byte_o | output | CMD_W | Byte to load |
| ibf_irq_en_o | output | 1 | Input interrupt enable |
| obf_irq_en_o | output | 1 | Output interrupt enable |
| rx_valid_o | output | 1 | Receive stream valid |
| rx_ready_i | input | 1 | Receive stream ready |
| rx_is_cmd_o | output | 1 | Receive item is a command byte |
| rx_byte_o | output | CMD_W | Receive item byte |
| tx_valid_i | input | 1 | Return stream valid |
| tx_ready_o | output | 1 | Return stream ready |
| tx_byte_i | input | CMD_W | Return byte |
| cmd_busy_o | output | 1 | A command still has bytes to move |

## Verification
Corrupted remaining counts show up within one host transaction. The host reads one reply byte too many or too few, or `cmd_busy_o` stays high after the final read. A broken output-enable policy shows as a missing second reply byte or an extra load after the final read, within a few cycles of the host's read event. A wrong flush order shows up in the same command: the cycle stamps of the two clear strobes come out reversed, or a stale byte is still readable after the new command has been accepted.

// File: rtl/mbx_seq_pkg.sv
package mbx_seq_pkg;
  typedef enum logic [2:0] {
    SQ_DISPATCH,
    SQ_FLUSH,
    SQ_TAKE,
    SQ_STEP,
    SQ_SEND
  } sq_state_e;
endpackage

// File: rtl/mbx_evt_pend.sv
module mbx_evt_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic ibf_evt_i,
  input  logic obf_evt_i,
  input  logic obf_en_i,
  input  logic ibf_take_i,
  input  logic obf_take_i,
  input  logic obf_drop_i,
  output logic ibf_pend_o,
  output logic obf_pend_o
);
  logic ibf_q, obf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf_q <= 1'b0;
      obf_q <= 1'b0;
    end else begin
      ibf_q <= (ibf_q & ~ibf_take_i) | ibf_evt_i;
      obf_q <= ((obf_q & ~obf_take_i) | (obf_evt_i & obf_en_i)) & ~obf_drop_i;
    end
  end

  assign ibf_pend_o = ibf_q;
  assign obf_pend_o = obf_q;

  // R10: a latched input event persists until served
  a_r10_ibf_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf_q && !ibf_take_i) |=> ibf_q);
  // R10: an output event arriving while disabled is not latched
  a_r10_obf_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!obf_q && !obf_en_i) |=> !obf_q);
endmodule

// File: rtl/mbx_cmd_lut.sv
module mbx_cmd_lut #(
  parameter int CMD_W    = 8,
  parameter int NUM_CMDS = 16,
  parameter int CNT_W    = 4,
  parameter logic [NUM_CMDS*2*CNT_W-1:0] CMD_TABLE = '0
) (
  input  logic [CMD_W-1:0] code_i,
  output logic             known_o,
  output logic [CNT_W-1:0] rx_cnt_o,
  output logic [CNT_W-1:0] tx_cnt_o
);
  localparam int IDX_W = (NUM_CMDS > 1) ? $clog2(NUM_CMDS) : 1;
  localparam int ENT_W = 2 * CNT_W;

  logic [CNT_W-1:0] rx_tab [NUM_CMDS];
  logic [CNT_W-1:0] tx_tab [NUM_CMDS];
  logic [IDX_W-1:0] idx;

  for (genvar g = 0; g < NUM_CMDS; g++) begin : g_ent
    assign tx_tab[g] = CMD_TABLE[g*ENT_W +: CNT_W];
    assign rx_tab[g] = CMD_TABLE[g*ENT_W+CNT_W +: CNT_W];
  end

  assign idx     = code_i[IDX_W-1:0];
  assign known_o = (int'(code_i) < NUM_CMDS);

  always_comb begin
    rx_cnt_o = '0;
    tx_cnt_o = '0;
    if (known_o) begin
      rx_cnt_o = rx_tab[idx];
      tx_cnt_o = tx_tab[idx];
    end
  end
endmodule

// File: rtl/mbx_seq_core.sv
module mbx_seq_core
  import mbx_seq_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ibf_pend_i,
  input  logic             obf_pend_i,
  output logic             ibf_take_o,
  output logic             obf_take_o,
  output logic             obf_drop_o,
  input  logic             mb_cmd_i,
  input  logic [CMD_W-1:0] mb_byte_i,
  input  logic             mb_obf_flag_i,
  input  logic             lut_known_i,
  input  logic [CNT_W-1:0] lut_rx_i,
  input  logic [CNT_W-1:0] lut_tx_i,
  output logic             clr_ibf_o,
  output logic             clr_obf_o,
  output logic             load_obf_o,
  output logic [CMD_W-1:0] out_byte_o,
  output logic             obf_en_o,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  output logic             rx_is_cmd_o,
  output logic [CMD_W-1:0] rx_byte_o,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  input  logic [CMD_W-1:0] tx_byte_i,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  sq_state_e        state_q, state_d;
  logic [CNT_W-1:0] rem_rx_q, rem_rx_d;
  logic [CNT_W-1:0] rem_tx_q, rem_tx_d;
  logic             obf_en_q, obf_en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_DISPATCH;
      rem_rx_q <= '0;
      rem_tx_q <= '0;
      obf_en_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rem_rx_q <= rem_rx_d;
      rem_tx_q <= rem_tx_d;
      obf_en_q <= obf_en_d;
    end
  end

  always_comb begin
    state_d    = state_q;
    rem_rx_d   = rem_rx_q;
    rem_tx_d   = rem_tx_q;
    obf_en_d   = obf_en_q;
    ibf_take_o = 1'b0;
    obf_take_o = 1'b0;
    obf_drop_o = 1'b0;
    clr_ibf_o  = 1'b0;
    clr_obf_o  = 1'b0;
    load_obf_o = 1'b0;
    rx_valid_o = 1'b0;
    tx_ready_o = 1'b0;
    unique case (state_q)
      SQ_DISPATCH: begin
        if (ibf_pend_i) begin
          ibf_take_o = 1'b1;
          state_d    = SQ_FLUSH;
        end else if (obf_pend_i) begin
          obf_take_o = 1'b1;
          state_d    = SQ_STEP;
        end
      end
      SQ_FLUSH: begin
        if (mb_cmd_i) begin
          rem_rx_d   = '0;
          rem_tx_d   = '0;
          obf_en_d   = 1'b0;
          obf_drop_o = 1'b1;
          clr_obf_o  = mb_obf_flag_i;
        end
        state_d = SQ_TAKE;
      end
      SQ_TAKE: begin
        if (mb_cmd_i) begin
          rx_valid_o = 1'b1;
          if (rx_ready_i) begin
            clr_ibf_o = 1'b1;
            rem_rx_d  = lut_known_i ? lut_rx_i : '0;
            rem_tx_d  = lut_known_i ? lut_tx_i : '0;
            state_d   = SQ_STEP;
          end
        end else if (rem_rx_q != '0) begin
          rx_valid_o = 1'b1;
          if (rx_ready_i) begin
            clr_ibf_o = 1'b1;
            rem_rx_d  = rem_rx_q - CNT_ONE;
            state_d   = SQ_STEP;
          end
        end else begin
          clr_ibf_o = 1'b1;
          state_d   = SQ_DISPATCH;
        end
      end
      SQ_STEP: begin
        if (rem_rx_q != '0) begin
          obf_en_d = 1'b0;
          state_d  = SQ_DISPATCH;
        end else if (rem_tx_q != '0) begin
          state_d = SQ_SEND;
        end else begin
          obf_en_d = 1'b0;
          state_d  = SQ_DISPATCH;
        end
      end
      SQ_SEND: begin
        tx_ready_o = 1'b1;
        if (tx_valid_i) begin
          load_obf_o = 1'b1;
          rem_tx_d   = rem_tx_q - CNT_ONE;
          obf_en_d   = (rem_tx_q != CNT_ONE);
          state_d    = SQ_DISPATCH;
        end
      end
      default: state_d = SQ_DISPATCH;
    endcase
  end

  assign out_byte_o  = tx_byte_i;
  assign rx_is_cmd_o = mb_cmd_i;
  assign rx_byte_o   = mb_byte_i;
  assign obf_en_o    = obf_en_q;
  assign busy_o      = (rem_rx_q != '0) || (rem_tx_q != '0);

  // R4: a stalled receive item stays offered and unchanged
  a_r4_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_byte_o) && $stable(rx_is_cmd_o)));
  // R8: output interrupt stays off while host data is awaited
  a_r8_rx_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_DISPATCH && rem_rx_q != '0) |-> !obf_en_q);
  // R7: parked between sends means the output interrupt is on
  a_r7_send_wait_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_DISPATCH && rem_rx_q == '0 && rem_tx_q != '0) |-> obf_en_q);
  // R11: a load is never followed at once by another
  a_r11_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_obf_o |=> !load_obf_o);
  // R6: after the last byte is loaded the command is finished
  a_r6_last_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (load_obf_o && rem_tx_q == CNT_ONE) |=> (!obf_en_q && !busy_o));
endmodule

// File: rtl/mbx_cmd_sequencer.sv
module mbx_cmd_sequencer #(
  parameter int CMD_W    = 8,
  parameter int NUM_CMDS = 16,
  parameter int CNT_W    = 4,
  parameter logic [NUM_CMDS*2*CNT_W-1:0] CMD_TABLE =
    128'h0000_0000_0000_0000_0000_1122_1003_0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mb_ibf_evt_i,
  input  logic             mb_obf_evt_i,
  input  logic             mb_cmd_i,
  input  logic [CMD_W-1:0] mb_byte_i,
  input  logic             mb_obf_flag_i,
  output logic             mb_clr_ibf_o,
  output logic             mb_clr_obf_o,
  output logic             mb_load_obf_o,
  output logic [CMD_W-1:0] mb_out_byte_o,
  output logic             ibf_irq_en_o,
  output logic             obf_irq_en_o,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  output logic             rx_is_cmd_o,
  output logic [CMD_W-1:0] rx_byte_o,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  input  logic [CMD_W-1:0] tx_byte_i,
  output logic             cmd_busy_o
);
  logic             ibf_pend, obf_pend, ibf_take, obf_take, obf_drop;
  logic             lut_known;
  logic [CNT_W-1:0] lut_rx, lut_tx;
  logic             ibf_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ibf_en_q <= 1'b0;
    else        ibf_en_q <= 1'b1;
  end
  assign ibf_irq_en_o = ibf_en_q;

  mbx_evt_pend u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .ibf_evt_i  (mb_ibf_evt_i & ibf_en_q),
    .obf_evt_i  (mb_obf_evt_i),
    .obf_en_i   (obf_irq_en_o),
    .ibf_take_i (ibf_take),
    .obf_take_i (obf_take),
    .obf_drop_i (obf_drop),
    .ibf_pend_o (ibf_pend),
    .obf_pend_o (obf_pend)
  );

  mbx_cmd_lut #(
    .CMD_W    (CMD_W),
    .NUM_CMDS (NUM_CMDS),
    .CNT_W    (CNT_W),
    .CMD_TABLE(CMD_TABLE)
  ) u_lut (
    .code_i  (mb_byte_i),
    .known_o (lut_known),
    .rx_cnt_o(lut_rx),
    .tx_cnt_o(lut_tx)
  );

  mbx_seq_core #(
    .CMD_W(CMD_W),
    .CNT_W(CNT_W)
  ) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .ibf_pend_i   (ibf_pend),
    .obf_pend_i   (obf_pend),
    .ibf_take_o   (ibf_take),
    .obf_take_o   (obf_take),
    .obf_drop_o   (obf_drop),
    .mb_cmd_i     (mb_cmd_i),
    .mb_byte_i    (mb_byte_i),
    .mb_obf_flag_i(mb_obf_flag_i),
    .lut_known_i  (lut_known),
    .lut_rx_i     (lut_rx),
    .lut_tx_i     (lut_tx),
    .clr_ibf_o    (mb_clr_ibf_o),
    .clr_obf_o    (mb_clr_obf_o),
    .load_obf_o   (mb_load_obf_o),
    .out_byte_o   (mb_out_byte_o),
    .obf_en_o     (obf_irq_en_o),
    .rx_valid_o   (rx_valid_o),
    .rx_ready_i   (rx_ready_i),
    .rx_is_cmd_o  (rx_is_cmd_o),
    .rx_byte_o    (rx_byte_o),
    .tx_valid_i   (tx_valid_i),
    .tx_ready_o   (tx_ready_o),
    .tx_byte_i    (tx_byte_i),
    .busy_o       (cmd_busy_o)
  );

  // R3: flush and release never share a cycle
  a_r3_no_clr_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !(mb_clr_obf_o && mb_clr_ibf_o));
  // R2: only a command byte can discard the output register
  a_r2_flush_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    mb_clr_obf_o |-> mb_cmd_i);
  // R11: a load only happens inside a return-stream handshake
  a_r11_load_hs: assert property (@(posedge clk) disable iff (!rst_n)
    mb_load_obf_o |-> (tx_valid_i && tx_ready_o));
endmodule

// File: tb/mbx_cmd_sequencer_tb.sv
module mbx_cmd_sequencer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // mailbox model
  logic       ibf = 1'b0, obf = 1'b0, ibf_evt = 1'b0, obf_evt = 1'b0;
  logic       mb_cmd = 1'b0;
  logic [7:0] mb_in = '0, mb_out = '0;
  logic       wr_req = 1'b0, wr_cmd = 1'b0, rd_req = 1'b0;
  logic [7:0] wr_byte = '0;
  // streams
  logic       rx_ready_b = 1'b1, tx_stall = 1'b0;
  logic [7:0] src_cnt = '0;

  logic       clr_ibf, clr_obf, load_obf, ibf_en, obf_en, rx_valid, rx_is_cmd, tx_ready, busy;
  logic [7:0] out_byte, rx_byte;

  mbx_cmd_sequencer dut_i (
    .clk(clk), .rst_n(rst_n),
    .mb_ibf_evt_i(ibf_evt), .mb_obf_evt_i(obf_evt),
    .mb_cmd_i(mb_cmd), .mb_byte_i(mb_in), .mb_obf_flag_i(obf),
    .mb_clr_ibf_o(clr_ibf), .mb_clr_obf_o(clr_obf), .mb_load_obf_o(load_obf),
    .mb_out_byte_o(out_byte), .ibf_irq_en_o(ibf_en), .obf_irq_en_o(obf_en),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready_b), .rx_is_cmd_o(rx_is_cmd),
    .rx_byte_o(rx_byte), .tx_valid_i(!tx_stall), .tx_ready_o(tx_ready),
    .tx_byte_i(8'hA0 + src_cnt), .cmd_busy_o(busy)
  );

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    ibf_evt <= 1'b0;
    obf_evt <= 1'b0;
    if (wr_req) begin
      ibf <= 1'b1; mb_in <= wr_byte; mb_cmd <= wr_cmd; ibf_evt <= 1'b1;
    end else if (clr_ibf) ibf <= 1'b0;
    if (clr_obf) obf <= 1'b0;
    else if (load_obf) begin obf <= 1'b1; mb_out <= out_byte; end
    else if (rd_req) begin obf <= 1'b0; obf_evt <= 1'b1; end
    if (!tx_stall && tx_ready) src_cnt <= src_cnt + 8'd1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboards and monitor
  logic [8:0] rx_exp[$];
  logic [7:0] rd_exp[$];
  int load_cnt = 0, clr_obf_cnt = 0, clr_obf_cyc = 0, clr_ibf_cyc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (load_obf) load_cnt++;
      if (clr_obf) begin clr_obf_cnt++; clr_obf_cyc = cyc; end
      if (clr_ibf) clr_ibf_cyc = cyc;
      if (rx_valid && rx_ready_b) begin
        if (rx_exp.size() == 0) chk(0, "R4/R9 unexpected rx item", {rx_is_cmd, rx_byte}, 0);
        else begin
          logic [8:0] e;
          e = rx_exp.pop_front();
          chk({rx_is_cmd, rx_byte} == e, "R4 rx item", {rx_is_cmd, rx_byte}, e);
        end
      end
    end
  end

  task automatic host_write(input bit is_cmd, input logic [7:0] b);
    while (ibf) @(negedge clk);
    wr_req = 1'b1; wr_cmd = is_cmd; wr_byte = b;
    @(negedge clk);
    wr_req = 1'b0;
    if (is_cmd || 1) ;
  endtask

  task automatic host_cmd(input logic [7:0] b);
    rx_exp.push_back({1'b1, b});
    host_write(1'b1, b);
  endtask

  task automatic host_read(input string tag);
    logic [7:0] e;
    while (!(ibf == 1'b0 && obf == 1'b1)) @(negedge clk);
    e = rd_exp.pop_front();
    chk(mb_out == e, tag, mb_out, e);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lc;
    logic [7:0] base;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(obf_en == 0 && busy == 0 && rx_valid == 0, "R1 reset outputs", {obf_en, busy, rx_valid}, 0);
    chk(clr_ibf == 0 && clr_obf == 0 && load_obf == 0, "R1 no strobes", {clr_ibf, clr_obf, load_obf}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ibf_en == 1, "R1 ibf irq enabled", ibf_en, 1);

    // R8: command with no data
    host_cmd(8'h00); settle();
    chk(busy == 0 && obf_en == 0, "R8 empty command idle", {busy, obf_en}, 0);
    chk(ibf == 0, "R4 input flag released", ibf, 0);

    // R6: single send, with a stalled return stream (R11)
    tx_stall = 1'b1;
    base = src_cnt;
    host_cmd(8'h01); settle();
    chk(obf == 0 && tx_ready == 1, "R11 stalled send waits", {obf, tx_ready}, 2'b01);
    tx_stall = 1'b0;
    rd_exp.push_back(8'hA0 + base);
    host_read("R6 single byte");
    settle();
    chk(obf_en == 0 && busy == 0, "R6 idle after last byte", {obf_en, busy}, 0);
    // R10: output event while disabled has no effect
    chk(load_cnt == 1, "R10 no load after disabled event", load_cnt, 1);

    // R7: three sends
    base = src_cnt;
    host_cmd(8'h02);
    while (!obf) @(negedge clk);
    @(negedge clk);
    chk(obf_en == 1, "R7 obf irq on while more follow", obf_en, 1);
    lc = load_cnt; settle();
    chk(load_cnt == lc, "R7 no load before host read", load_cnt, lc);
    for (int k = 0; k < 3; k++) begin
      rd_exp.push_back(8'hA0 + base + 8'(k));
      host_read("R7 multi byte");
    end
    settle();
    chk(obf_en == 0 && busy == 0, "R6 done after three", {obf_en, busy}, 0);

    // R5/R8: one receive byte
    host_cmd(8'h03); settle();
    chk(busy == 1 && obf_en == 0, "R8 waiting for data", {busy, obf_en}, 2'b10);
    rx_exp.push_back({1'b0, 8'h55});
    host_write(1'b0, 8'h55); settle();
    chk(busy == 0, "R5 receive-only finished", busy, 0);

    // R5: two in, two out (receive first)
    base = src_cnt;
    host_cmd(8'h04); settle();
    chk(obf == 0, "R5 no send before receive", obf, 0);
    rx_exp.push_back({1'b0, 8'h11}); host_write(1'b0, 8'h11);
    rx_exp.push_back({1'b0, 8'h22}); host_write(1'b0, 8'h22);
    rd_exp.push_back(8'hA0 + base);      host_read("R5 send after receive");
    rd_exp.push_back(8'hA0 + base + 1);  host_read("R5 second send");
    settle();
    chk(busy == 0, "R5 mixed command finished", busy, 0);

    // R5: unknown command ends at once
    host_cmd(8'h80); settle();
    chk(busy == 0 && obf == 0, "R5 unknown command idle", {busy, obf}, 0);

    // R9: stray data byte
    lc = load_cnt;
    host_write(1'b0, 8'h77); settle();
    chk(ibf == 0 && busy == 0 && load_cnt == lc, "R9 stray byte dropped", {ibf, busy}, 0);

    // R2/R3: cancel with stale output byte
    base = src_cnt;
    host_cmd(8'h02);
    rd_exp.push_back(8'hA0 + base); host_read("R2 first byte before cancel");
    while (!obf) @(negedge clk);
    lc = clr_obf_cnt;
    host_cmd(8'h00); settle();
    chk(clr_obf_cnt == lc + 1, "R3 stale byte flushed", clr_obf_cnt, lc + 1);
    chk(clr_obf_cyc < clr_ibf_cyc, "R3 flush precedes release", clr_obf_cyc, clr_ibf_cyc);
    chk(obf == 0 && busy == 0 && obf_en == 0, "R2 command aborted", {obf, busy, obf_en}, 0);
    base = src_cnt;
    host_cmd(8'h01);
    rd_exp.push_back(8'hA0 + base); host_read("R2 fresh answer after cancel");
    settle();

    // R4: receive back-pressure holds the input flag
    rx_ready_b = 1'b0;
    host_cmd(8'h00);
    repeat (10) @(negedge clk);
    chk(ibf == 1 && rx_valid == 1, "R4 stalled item holds", {ibf, rx_valid}, 2'b11);
    rx_ready_b = 1'b1;
    settle();
    chk(ibf == 0, "R4 released after handshake", ibf, 0);

    chk(rx_exp.size() == 0 && rd_exp.size() == 0, "R4 scoreboards drained", rx_exp.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule